// File: doc/BRIEF.md
# Serial Link Mode and Direction Controller

This block is the control core of a bidirectional 12-bit serial link end. It turns two mode pins and a direction pin into one of three states: serializer, deserializer or power-down. It also drives the inverted direction signal that steers a partner device, and the enables for both sides of the parallel port. It holds the last deserialized word on the parallel outputs. Every input is taken to be synchronous to the system clock `clk`, except the reference clock, which passes through a synchronizer first.

The block also watches the reference clock. After power-up it selects the externally supplied serial bit clock as the serialization source. On the first reference activity it moves for good to the reference (PLL) source. Only a power-down followed by a wake-up with the reference held low can bring back the external source. If the reference stops for `LOSS_CYC` clock cycles, the PLL and the serial drivers are shut down without a full reset, and bias stays on. The next reference edge brings them back. A lock-wait counter opens the data-valid gate a programmable number of cycles after the PLL is enabled.

Top module: `link_mode_ctrl`

## Requirements
- R1: Power-down is `mode_i == 2'b00`, and it is reported on `pwrdn_o`. While in power-down, the following outputs are all 0: `par_oe_o`, `par_in_en_o`, `ser_oe_o`, `pll_en_o`, `bias_en_o`, `ser_mode_o`, `des_mode_o`, `ref_lost_o` and `data_ok_o`. On each clock edge in power-down, all internal state clears, `par_word_o` becomes 0 and `clk_src_ref_o` becomes 0. The asynchronous `rst_n` does the same.
- R2: `range_o` is one-hot and follows the mode. Mode 01 gives bit 0 (20–56 MHz), mode 10 gives bit 1 (5–15 MHz), mode 11 gives bit 2 (10–30 MHz) and power-down gives 000.
- R3: `dir_o` is always the logical inverse of `dir_i`.
- R4: Outside power-down, `dir_i=1` selects the serializer (`ser_mode_o=1`, `par_in_en_o=1`, `par_oe_o=0`). Outside power-down, `dir_i=0` selects the deserializer (`des_mode_o=1`, `par_oe_o=1`, `par_in_en_o=0`).
- R5: After reset or power-down, `clk_src_ref_o=0`, which selects the external bit clock. A level change on `ref_clk_i` sets `clk_src_ref_o` at the third rising clock edge after the change. It stays set when the reference stops.
- R6: Leaving power-down with `ref_clk_i` held high counts as activity, so `clk_src_ref_o` sets again. Leaving it with `ref_clk_i` held low leaves `clk_src_ref_o` at 0.
- R7: With `clk_src_ref_o=1`, `ref_lost_o` rises once `LOSS_CYC` clock edges pass with no recognised reference edge. While it is high, `pll_en_o` and `ser_oe_o` are 0 and `bias_en_o` stays 1. The next recognised edge clears `ref_lost_o` at that clock edge.
- R8: In deserializer mode, `par_word_o` loads `rx_word_i` on each edge where `rx_word_vld_i=1`. In serializer mode, or with the valid low, it keeps its last value.
- R9: `pll_en_o` is 1 outside power-down when `clk_src_ref_o=1` and `ref_lost_o=0`. A counter clears while the PLL is disabled and counts enabled cycles, saturating at all ones. `data_ok_o` is 1 when `pll_en_o=1` and that count is at least `lock_wait_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode pins {high, low}; 00 is power-down |
| dir_i | input | 1 | 1 = serializer, 0 = deserializer |
| ref_clk_i | input | 1 | Reference clock, asynchronous |
| lock_wait_i | input | LOCK_W | Enabled cycles before data is valid |
| rx_word_i | input | WORD_W | Word from the deserializer datapath |
| rx_word_vld_i | input | 1 | Word boundary strobe |
| dir_o | output | 1 | Inverted direction for partner device |
| pwrdn_o | output | 1 | Power-down decoded |
| range_o | output | 3 | One-hot reference range select |
| ser_mode_o | output | 1 | Serializer active |
| des_mode_o | output | 1 | Deserializer active |
| par_oe_o | output | 1 | Parallel output driver enable |
| par_in_en_o | output | 1 | Parallel input buffer enable |
| ser_oe_o | output | 1 | Serial clock/data driver enable |
| bias_en_o | output | 1 | Internal references enabled |
| clk_src_ref_o | output | 1 | 1 = reference clock source, 0 = external bit clock |
| ref_lost_o | output | 1 | Reference declared stopped |
| pll_en_o | output | 1 | PLL enable |
| data_ok_o | output | 1 | Lock wait elapsed, data may be captured |
| par_word_o | output | WORD_W | Held parallel output word |

## Verification
A source latch stuck in the wrong state shows at once on `clk_src_ref_o` and `pll_en_o`. It shows again after a power-down, when the way out of that power-down decides which source is selected. An idle counter that is off by one moves the rise of `ref_lost_o`, and with it the fall of `ser_oe_o`, by a single cycle. Only a bench that samples every cycle across a stopped reference catches that. A held word that is corrupted or cleared when the device turns to serializer shows on `par_word_o` in the very next cycle. The lock gate is checked against several wait values, with an edge at zero, where the gate opens in the same cycle as the enable.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

  typedef enum logic [1:0] {
    MD_OFF  = 2'b00,
    MD_WIDE = 2'b01,
    MD_LOW  = 2'b10,
    MD_MID  = 2'b11
  } lmc_mode_e;

  function automatic logic mode_is_off(input logic [1:0] m);
    return (m == MD_OFF);
  endfunction

  function automatic logic [2:0] range_onehot(input logic [1:0] m);
    logic [2:0] r;
    unique case (m)
      MD_WIDE: r = 3'b001;
      MD_LOW:  r = 3'b010;
      MD_MID:  r = 3'b100;
      default: r = 3'b000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lmc_ref_watch.sv
module lmc_ref_watch #(
  parameter int LOSS_CYC = 64,
  localparam int IW = $clog2(LOSS_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic ref_i,
  output logic edge_o,
  output logic src_ref_o,
  output logic lost_o
);

  localparam logic [IW-1:0] IDLE_MAX = IW'(LOSS_CYC);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic          src_q;
  logic [IW-1:0] idle_q;

  assign edge_o = sync_q[1] ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else if (clr_i) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ref_i};
      prev_q <= sync_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         src_q <= 1'b0;
    else if (clr_i)     src_q <= 1'b0;
    else if (edge_o)    src_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_q <= '0;
    else if (clr_i || edge_o)   idle_q <= '0;
    else if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
  end

  assign src_ref_o = src_q;
  assign lost_o    = src_q && (idle_q == IDLE_MAX);

endmodule

// File: rtl/lmc_lock_gate.sv
module lmc_lock_gate #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] wait_i,
  output logic          open_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = run_i && (cnt_q >= wait_i);

endmodule

// File: rtl/lmc_word_hold.sv
module lmc_word_hold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (ld_i)  q_o <= d_i;
  end

endmodule

// File: rtl/link_mode_ctrl.sv
module link_mode_ctrl #(
  parameter int WORD_W   = 12,
  parameter int LOSS_CYC = 64,
  parameter int LOCK_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              dir_i,
  input  logic              ref_clk_i,
  input  logic [LOCK_W-1:0] lock_wait_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_word_vld_i,
  output logic              dir_o,
  output logic              pwrdn_o,
  output logic [2:0]        range_o,
  output logic              ser_mode_o,
  output logic              des_mode_o,
  output logic              par_oe_o,
  output logic              par_in_en_o,
  output logic              ser_oe_o,
  output logic              bias_en_o,
  output logic              clk_src_ref_o,
  output logic              ref_lost_o,
  output logic              pll_en_o,
  output logic              data_ok_o,
  output logic [WORD_W-1:0] par_word_o
);
  import lmc_pkg::*;

  logic pd;
  logic ref_edge;
  logic src_ref;
  logic lost_raw;
  logic lost;
  logic word_ld;

  assign pd          = mode_is_off(mode_i);
  assign pwrdn_o     = pd;
  assign range_o     = range_onehot(mode_i);
  assign dir_o       = ~dir_i;
  assign ser_mode_o  = !pd && dir_i;
  assign des_mode_o  = !pd && !dir_i;
  assign par_oe_o    = des_mode_o;
  assign par_in_en_o = ser_mode_o;
  assign bias_en_o   = !pd;

  lmc_ref_watch #(.LOSS_CYC(LOSS_CYC)) u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (pd),
    .ref_i     (ref_clk_i),
    .edge_o    (ref_edge),
    .src_ref_o (src_ref),
    .lost_o    (lost_raw)
  );

  assign lost          = !pd && lost_raw;
  assign ref_lost_o    = lost;
  assign clk_src_ref_o = src_ref;
  assign pll_en_o      = !pd && src_ref && !lost_raw;
  assign ser_oe_o      = ser_mode_o && !lost;

  lmc_lock_gate #(.CW(LOCK_W)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (pll_en_o),
    .wait_i (lock_wait_i),
    .open_o (data_ok_o)
  );

  assign word_ld = des_mode_o && rx_word_vld_i;

  lmc_word_hold #(.W(WORD_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (pd),
    .ld_i  (word_ld),
    .d_i   (rx_word_i),
    .q_o   (par_word_o)
  );

endmodule

// File: rtl/link_mode_ctrl_chk.sv
module link_mode_ctrl_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_i,
  input logic              dir_o,
  input logic              pwrdn_o,
  input logic [2:0]        range_o,
  input logic              par_oe_o,
  input logic              par_in_en_o,
  input logic              ser_oe_o,
  input logic              bias_en_o,
  input logic              clk_src_ref_o,
  input logic              ref_lost_o,
  input logic              pll_en_o,
  input logic              data_ok_o,
  input logic [WORD_W-1:0] par_word_o
);

  a_r1_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_o |-> !(par_oe_o || par_in_en_o || ser_oe_o || pll_en_o || data_ok_o));

  a_r2_range_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(range_o) && (pwrdn_o == (range_o == 3'b000)));

  a_r3_dir_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    dir_o != dir_i);

  a_r4_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_oe_o && par_in_en_o));

  a_r5_src_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src_ref_o && !pwrdn_o) |=> clk_src_ref_o);

  a_r7_lost_keeps_bias: assert property (@(posedge clk) disable iff (!rst_n)
    ref_lost_o |-> (bias_en_o && !pll_en_o && !ser_oe_o));

  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwrdn_o && dir_i) |=> $stable(par_word_o));

  a_r9_gate_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
    data_ok_o |-> (pll_en_o && clk_src_ref_o));

endmodule

bind link_mode_ctrl link_mode_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dir_i         (dir_i),
  .dir_o         (dir_o),
  .pwrdn_o       (pwrdn_o),
  .range_o       (range_o),
  .par_oe_o      (par_oe_o),
  .par_in_en_o   (par_in_en_o),
  .ser_oe_o      (ser_oe_o),
  .bias_en_o     (bias_en_o),
  .clk_src_ref_o (clk_src_ref_o),
  .ref_lost_o    (ref_lost_o),
  .pll_en_o      (pll_en_o),
  .data_ok_o     (data_ok_o),
  .par_word_o    (par_word_o)
);

// File: tb/link_mode_ctrl_bench.sv
module link_mode_ctrl_bench;
  localparam int WORD_W = 12;
  localparam int LOSS   = 64;
  localparam int LOCK_W = 10;
  localparam int LOCK_MAX = (1 << LOCK_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode_i = 2'b01;
  logic              dir_i = 1'b0;
  logic              ref_clk_i = 1'b0;
  logic [LOCK_W-1:0] lock_wait_i = 10'd5;
  logic [WORD_W-1:0] rx_word_i = '0;
  logic              rx_word_vld_i = 1'b0;
  logic              dir_o, pwrdn_o, ser_mode_o, des_mode_o, par_oe_o, par_in_en_o;
  logic              ser_oe_o, bias_en_o, clk_src_ref_o, ref_lost_o, pll_en_o, data_ok_o;
  logic [2:0]        range_o;
  logic [WORD_W-1:0] par_word_o;

  always #5 clk = ~clk;

  link_mode_ctrl #(.WORD_W(WORD_W), .LOSS_CYC(LOSS), .LOCK_W(LOCK_W)) u_link_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_i(dir_i), .ref_clk_i(ref_clk_i),
    .lock_wait_i(lock_wait_i), .rx_word_i(rx_word_i), .rx_word_vld_i(rx_word_vld_i),
    .dir_o(dir_o), .pwrdn_o(pwrdn_o), .range_o(range_o), .ser_mode_o(ser_mode_o),
    .des_mode_o(des_mode_o), .par_oe_o(par_oe_o), .par_in_en_o(par_in_en_o),
    .ser_oe_o(ser_oe_o), .bias_en_o(bias_en_o), .clk_src_ref_o(clk_src_ref_o),
    .ref_lost_o(ref_lost_o), .pll_en_o(pll_en_o), .data_ok_o(data_ok_o),
    .par_word_o(par_word_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference model
  int m_hist[$] = '{0, 0, 0};
  int m_src = 0, m_idle = 0, m_lock = 0, m_word = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic int exp_range(input int m);
    if (m == 1) return 1;
    if (m == 2) return 2;
    if (m == 3) return 4;
    return 0;
  endfunction

  always @(posedge clk) begin
    int pd, edge_seen, pll_old;
    pd = (mode_i == 2'b00) ? 1 : 0;
    if (!rst_n || pd != 0) begin
      m_hist = '{0, 0, 0};
      m_src = 0; m_idle = 0; m_lock = 0; m_word = 0;
    end else begin
      pll_old   = (m_src != 0 && m_idle != LOSS) ? 1 : 0;
      edge_seen = (m_hist[1] != m_hist[2]) ? 1 : 0;
      m_hist    = '{int'(ref_clk_i), m_hist[0], m_hist[1]};
      if (edge_seen != 0) m_src = 1;
      if (edge_seen != 0) m_idle = 0;
      else if (m_idle < LOSS) m_idle++;
      if (pll_old == 0) m_lock = 0;
      else if (m_lock < LOCK_MAX) m_lock++;
      if (!dir_i && rx_word_vld_i) m_word = int'(rx_word_i);
    end
    #1;
    if (rst_n && !done) begin
      int p, lost, pll, ser;
      p    = (mode_i == 2'b00) ? 1 : 0;
      lost = (p == 0 && m_src != 0 && m_idle == LOSS) ? 1 : 0;
      pll  = (p == 0 && m_src != 0 && lost == 0) ? 1 : 0;
      ser  = (p == 0 && dir_i) ? 1 : 0;
      chk("R1 pwrdn", int'(pwrdn_o), p);
      chk("R1 bias", int'(bias_en_o), 1 - p);
      chk("R2 range", int'(range_o), exp_range(int'(mode_i)));
      chk("R3 dir_o", int'(dir_o), int'(!dir_i));
      chk("R4 ser_mode", int'(ser_mode_o), ser);
      chk("R4 des_mode", int'(des_mode_o), (p == 0 && !dir_i) ? 1 : 0);
      chk("R4 par_in_en", int'(par_in_en_o), ser);
      chk("R4 par_oe", int'(par_oe_o), (p == 0 && !dir_i) ? 1 : 0);
      chk("R5 clk_src", int'(clk_src_ref_o), m_src);
      chk("R7 ref_lost", int'(ref_lost_o), lost);
      chk("R7 ser_oe", int'(ser_oe_o), (ser != 0 && lost == 0) ? 1 : 0);
      chk("R9 pll_en", int'(pll_en_o), pll);
      chk("R9 data_ok", int'(data_ok_o), (pll != 0 && m_lock >= int'(lock_wait_i)) ? 1 : 0);
      chk("R8 par_word", int'(par_word_o), m_word);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_ref(input int halves, input int half_len);
    for (int i = 0; i < halves; i++) begin
      ref_clk_i = ~ref_clk_i;
      step(half_len);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R4/R8: deserializer loads words on valid only
    rx_word_i = 12'hA5C; rx_word_vld_i = 1'b1; step(1);
    rx_word_vld_i = 1'b0; rx_word_i = 12'h111; step(3);
    rx_word_i = 12'h3F0; rx_word_vld_i = 1'b1; step(1);
    // R8: turn to serializer, word held despite valid strobes
    dir_i = 1'b1; rx_word_i = 12'hFFF; step(4);
    rx_word_vld_i = 1'b0; step(2);
    // R2: mode sweep
    mode_i = 2'b10; step(3);
    mode_i = 2'b11; step(3);
    mode_i = 2'b01; step(2);
    // R5/R9: reference activity, lock wait 5
    toggle_ref(20, 3);
    // R7: reference stops high, loss then recovery
    ref_clk_i = 1'b1; step(LOSS + 10);
    toggle_ref(10, 2);
    // R7: stops low in deserializer mode
    dir_i = 1'b0; rx_word_i = 12'h5A5; rx_word_vld_i = 1'b1; step(1);
    rx_word_vld_i = 1'b0;
    ref_clk_i = 1'b0; step(LOSS + 6);
    // R1/R6: power-down with reference high, wake with it high
    mode_i = 2'b00; ref_clk_i = 1'b1; step(5);
    mode_i = 2'b11; step(10);
    // R6: power-down with reference low, wake with it low
    mode_i = 2'b00; ref_clk_i = 1'b0; step(4);
    mode_i = 2'b01; dir_i = 1'b1; step(20);
    // R9: zero lock wait
    lock_wait_i = 10'd0;
    toggle_ref(8, 2);
    // R9: longer lock wait
    mode_i = 2'b00; step(2);
    mode_i = 2'b10; lock_wait_i = 10'd40;
    toggle_ref(40, 2);
    // R1: asynchronous reset mid-run
    rst_n = 1'b0; step(2);
    rst_n = 1'b1; step(4);
    finish_run();
  end

endmodule